// File: doc/BRIEF.md
# Network Controller Interrupt Event Controller

This block keeps the interrupt state of a network controller. A 32-bit event register records which of thirteen conditions (transmit, receive, management, error and bus events) have occurred. Beside it, a 32-bit enable mask selects which of those conditions may interrupt the processor. Each of the thirteen conditions has its own interrupt line. Each line is high while its event bit and its mask bit are both set.

Event pulses from the datapath set event bits. Software acknowledges an event by writing a one to its bit. Two writes to neighbouring registers also raise events: a write to the management frame register, and a write to the transmit control register that requests a graceful stop. The lines are registered, and they are recomputed on every clock edge from the register values that take effect at that same edge.

Top module: `nic_irq_ctrl`

## Requirements
- R1: After reset, the event register, the mask register and all thirteen lines are 0.
- R2: A pulse on `evt_pulse[i]` sets event bit 19+i at the next clock edge. The event bits, by position, are: 31 HB, 30 BABR, 29 BABT, 28 GRA, 27 TXF, 26 TXB, 25 RXF, 24 RXB, 23 MII, 22 EB, 21 LC, 20 RL, 19 UN.
- R3: If a hardware set and a software clear reach the same event bit in the same cycle, the bit ends up set.
- R4: A write to offset 0x004 clears every event bit whose written data bit is 1. Event bits whose data bit is 0 keep their value.
- R5: The mask register at offset 0x008 takes all 32 written bits and reads them back unchanged.
- R6: Line k (k = 0..12) carries, in this order, the events TXF, TXB, UN, RL, RXF, RXB, MII, LC, HB, GRA, EB, BABT, BABR.
- R7: A line is 1 exactly when its event bit and its mask bit are both 1. The line changes at the same clock edge at which the event or mask register changes.
- R8: Any write to offset 0x040 (management frame) sets event bit 23 (MII).
- R9: A write to offset 0x0C4 (transmit control) with data bit 0 set sets event bit 28 (GRA). The same write with bit 0 clear changes no event.
- R10: Bits 18..0 of the event register always read 0. Neither pulses nor writes can set them. When `rd_en` is low, or the offset is not 0x004 or 0x008, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |
| evt_pulse | input | 13 | Hardware event pulses, bit i sets event bit 19+i |
| irq | output | 13 | Registered interrupt lines |

## Verification
The main check raises one event at a time while the mask is all ones. Each such event must appear on exactly one line, which shows whether the position-to-line map is right or has been permuted. Other cases raise every event at once under a zero mask or a single-bit mask, which shows that the masking works bit by bit. The directed tests then separate a partial acknowledge from a full one, a set and a clear in the same cycle from a clear alone, and a transmit control write with bit 0 set from one with bit 0 clear.

// File: rtl/nic_irq_ctrl.sv
`timescale 1ns/1ps
module nic_irq_ctrl #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] OFS_EVT  = 'h004,
  parameter logic [ADDR_W-1:0] OFS_MASK = 'h008,
  parameter logic [ADDR_W-1:0] OFS_MGMT = 'h040,
  parameter logic [ADDR_W-1:0] OFS_TXC  = 'h0C4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [12:0]       evt_pulse,
  output logic [12:0]       irq
);
  localparam int NEVT    = 13;
  localparam int EVT_LSB = 32 - NEVT;
  localparam int MII_BIT = 23;
  localparam int GRA_BIT = 28;
  localparam logic [31:0] EVT_KEEP = {{NEVT{1'b1}}, {EVT_LSB{1'b0}}};
  localparam int LINE_POS [NEVT] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  logic [31:0] evt_q, mask_q, evt_d, mask_d, set_v, clr_v;
  logic [NEVT-1:0] line_d;

  wire wr_evt  = wr_en && (addr == OFS_EVT);
  wire wr_mask = wr_en && (addr == OFS_MASK);
  wire wr_mgmt = wr_en && (addr == OFS_MGMT);
  wire wr_txc  = wr_en && (addr == OFS_TXC);

  assign set_v = {evt_pulse, {EVT_LSB{1'b0}}}
               | ({31'b0, wr_mgmt} << MII_BIT)
               | ({31'b0, wr_txc & wdata[0]} << GRA_BIT);
  assign clr_v  = wr_evt ? wdata : 32'b0;
  assign evt_d  = ((evt_q & ~clr_v) | set_v) & EVT_KEEP;
  assign mask_d = wr_mask ? wdata : mask_q;

  for (genvar g = 0; g < NEVT; g++) begin : g_line
    assign line_d[g] = evt_d[LINE_POS[g]] & mask_d[LINE_POS[g]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
      irq    <= '0;
    end else begin
      evt_q  <= evt_d;
      mask_q <= mask_d;
      irq    <= line_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == OFS_EVT)       rdata = evt_q;
      else if (addr == OFS_MASK) rdata = mask_q;
    end
  end
endmodule

// File: rtl/nic_irq_ctrl_chk.sv
`timescale 1ns/1ps
module nic_irq_ctrl_chk #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] OFS_EVT  = 'h004,
  parameter logic [ADDR_W-1:0] OFS_MASK = 'h008,
  parameter logic [ADDR_W-1:0] OFS_MGMT = 'h040,
  parameter logic [ADDR_W-1:0] OFS_TXC  = 'h0C4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [12:0]       evt_pulse,
  input logic [12:0]       irq,
  input logic [31:0]       evt_q,
  input logic [31:0]       mask_q
);
  a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((evt_q[31:19] & $past(evt_pulse)) == $past(evt_pulse)));
  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_EVT && evt_pulse == 13'b0) |=> ((evt_q & $past(wdata)) == 32'b0));
  a_r5_mask_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MASK) |=> (mask_q == $past(wdata)));
  a_r6_line0_txf: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] == (evt_q[27] & mask_q[27]));
  a_r6_line12_babr: assert property (@(posedge clk) disable iff (!rst_n)
    irq[12] == (evt_q[30] & mask_q[30]));
  a_r8_mii_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MGMT) |=> evt_q[23]);
  a_r9_gra_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_TXC && wdata[0]) |=> evt_q[28]);
  a_r10_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_EVT) |-> (rdata[18:0] == 19'b0));
endmodule

bind nic_irq_ctrl nic_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .OFS_EVT(OFS_EVT), .OFS_MASK(OFS_MASK),
  .OFS_MGMT(OFS_MGMT), .OFS_TXC(OFS_TXC)
) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse), .irq(irq),
  .evt_q(evt_q), .mask_q(mask_q)
);

// File: tb/nic_irq_ctrl_test.sv
`timescale 1ns/1ps
module nic_irq_ctrl_test;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [12:0] evt_pulse = '0, irq;
  int total = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nic_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse), .irq(irq));

  // {pulse, mask, expected lines}
  localparam logic [57:0] VEC [8] = '{
    {13'h0001, 32'hFFFF_FFFF, 13'h0004},
    {13'h1000, 32'hFFFF_FFFF, 13'h0100},
    {13'h0100, 32'hFFFF_FFFF, 13'h0001},
    {13'h1FFF, 32'h0000_0000, 13'h0000},
    {13'h1FFF, 32'h0800_0000, 13'h0001},
    {13'h0800, 32'hFFFF_FFFF, 13'h1000},
    {13'h0040, 32'h0200_0000, 13'h0010},
    {13'h0004, 32'hFFFF_FFFF, 13'h0080}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [12:0] p);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; evt_pulse = p;
    @(negedge clk);
    wr_en = 0; evt_pulse = '0;
  endtask

  task automatic pulse(input logic [12:0] p);
    @(negedge clk);
    evt_pulse = p;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    rd_en = 1; addr = a; #1;
    d = rdata;
    rd_en = 0;
  endtask

  initial begin
    logic [31:0] v;
    #20 rst_n = 1;
    rd(10'h004, v); chk("R1 event after reset", v, 0);
    rd(10'h008, v); chk("R1 mask after reset", v, 0);
    chk("R1 lines after reset", {19'b0, irq}, 0);

    for (int i = 0; i < 8; i++) begin
      wr(10'h004, 32'hFFFF_FFFF, 13'h0);
      wr(10'h008, VEC[i][44:13], 13'h0);
      pulse(VEC[i][57:45]);
      chk($sformatf("R6/R7 lines vector %0d", i), {19'b0, irq}, {19'b0, VEC[i][12:0]});
      rd(10'h004, v);
      chk($sformatf("R2 event vector %0d", i), v, {VEC[i][57:45], 19'b0});
    end

    wr(10'h004, 32'hFFFF_FFFF, 13'h0);
    wr(10'h008, 32'hFFFF_FFFF, 13'h0);
    pulse(13'h1FFF);
    wr(10'h004, 32'h0800_0000, 13'h0);
    rd(10'h004, v); chk("R4 partial clear", v, 32'hF7F8_0000);
    chk("R7 TXF line drops on clear", {31'b0, irq[0]}, 0);
    wr(10'h004, 32'hFFFF_FFFF, 13'h0001);
    rd(10'h004, v); chk("R3 set wins over clear", v, 32'h0008_0000);
    chk("R3 UN line stays", {19'b0, irq}, 32'h0004);

    wr(10'h004, 32'hFFFF_FFFF, 13'h0);
    wr(10'h040, 32'h1234_5678, 13'h0);
    rd(10'h004, v); chk("R8 management write sets MII", v, 32'h0080_0000);
    chk("R8 MII line", {19'b0, irq}, 32'h0040);

    wr(10'h004, 32'hFFFF_FFFF, 13'h0);
    wr(10'h0C4, 32'h0000_0002, 13'h0);
    rd(10'h004, v); chk("R9 bit0 clear no GRA", v, 0);
    wr(10'h0C4, 32'h0000_0001, 13'h0);
    rd(10'h004, v); chk("R9 bit0 set raises GRA", v, 32'h1000_0000);
    chk("R9 GRA line", {19'b0, irq}, 32'h0200);

    wr(10'h008, 32'hA5A5_5A5A, 13'h0);
    rd(10'h008, v); chk("R5 mask readback", v, 32'hA5A5_5A5A);

    wr(10'h004, 32'hFFFF_FFFF, 13'h0);
    wr(10'h004, 32'h0000_0000, 13'h0);
    rd(10'h004, v); chk("R10 write leaves low bits zero", v, 0);
    addr = 10'h004; #1;
    chk("R10 no read strobe", rdata, 0);
    rd(10'h00C, v); chk("R10 unmapped read", v, 0);

    @(negedge clk);
    rst_n = 0; #1;
    chk("R1 lines cleared by reset", {19'b0, irq}, 0);
    rd(10'h008, v); chk("R1 mask cleared by reset", v, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule